// File: doc/BRIEF.md
# USB Endpoint Mode Register Bank

This block holds one 8-bit control and status register for each of two USB endpoints, named endpoint A and endpoint B. Firmware reads and writes the registers through a simple byte-wide bus with address, strobes and a combinational read path. The serial interface engine (SIE) uses the same registers in three ways:

- It can replace an endpoint's 4-bit mode field when host traffic requires a mode change.
- It reports the result of each finished transaction, either ACK or NAK.
- It asks, through a combinational query, whether an incoming packet must be answered with a stall.

Each register packs four fields:

| Bit(s) | Field |
|--------|-------|
| 7 | stall |
| 6 | reserved, reads 0 |
| 5 | NAK-interrupt enable |
| 4 | sticky ACK-completed flag |
| 3:0 | mode |

The block also drives one interrupt pulse per endpoint.

Both registers share a single update path, and SIE updates win over firmware writes. While the SIE is changing either mode field, any firmware write in that same cycle is discarded. Firmware is expected to read back after every write and retry if the write was lost.

Top module: `usb_ep_mode_bank`

## Requirements
- R1: After reset, both registers read as 0x00 and no interrupt or stall response is driven.
- R2: While `fw_rd` is high, `fw_rdata` returns the addressed register in the same cycle as {stall, 0, nak_en, acked, mode[3:0]}. Endpoint A is at `BASE_ADDR` (default 0x45) and endpoint B is at `BASE_ADDR`+1. For any other address, or with `fw_rd` low, `fw_rdata` is 0x00.
- R3: Bit 6 ignores writes and always reads as 0.
- R4: An accepted firmware write loads stall from data bit 7, NAK-interrupt enable from bit 5 and mode from bits 3:0. The new value is visible from the next cycle.
- R5: When `txn_done` is high with `txn_acked` high, the addressed endpoint's ACK-completed bit is set from the next cycle and stays set.
- R6: An accepted firmware write clears the ACK-completed bit, whatever data bit 4 holds. If an ACK completion hits the same endpoint in the same cycle, the bit ends up set.
- R7: An ACK completion produces a one-cycle pulse on that endpoint's `ep_irq` bit in the following cycle.
- R8: A NAK completion (`txn_acked` low) pulses `ep_irq` in the following cycle only if that endpoint's NAK-interrupt enable is 1. Otherwise no pulse is produced.
- R9: `stall_resp` is high only when the queried endpoint has stall set and one of these holds:
  - `qry_is_in` is high and mode equals `MODE_ACK_IN` (default 4'hD);
  - `qry_is_in` is low and mode equals `MODE_ACK_OUT` (default 4'h9).
- R10: `sie_mode_wr` loads `sie_mode_val` into the selected endpoint's mode field. In the same cycle, every firmware write, to either register, is discarded with no effect on any field.
- R11: Reads have no side effects; repeated reads return the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fw_addr | input | ADDR_W | Firmware register address |
| fw_wdata | input | 8 | Firmware write data |
| fw_wr | input | 1 | Firmware write strobe |
| fw_rd | input | 1 | Firmware read strobe |
| fw_rdata | output | 8 | Firmware read data (combinational) |
| sie_mode_wr | input | 1 | SIE mode update request |
| sie_mode_ep | input | 1 | Endpoint for the SIE update (0 = A, 1 = B) |
| sie_mode_val | input | 4 | New mode value from the SIE |
| txn_done | input | 1 | A transaction has finished |
| txn_ep | input | 1 | Endpoint of the finished transaction |
| txn_acked | input | 1 | 1 = ended with ACK, 0 = ended with NAK |
| qry_ep | input | 1 | Endpoint being queried for stall |
| qry_is_in | input | 1 | 1 = IN packet, 0 = OUT packet |
| stall_resp | output | 1 | Answer the queried packet with a stall |
| ep_irq | output | 2 | Per-endpoint interrupt pulse |

## Verification
A field held wrongly inside the block shows up on the read port in the cycle after the stimulus that caused it. This is because reads are combinational and every field is visible in `fw_rdata`.

A wrong mode or stall bit also shows up at once in `stall_resp` under the matching query. A wrong NAK-enable bit shows up one cycle after the next NAK completion, as a missing or extra `ep_irq` pulse.

The lost-write collision is the most sensitive case. A firmware write that is wrongly accepted while the SIE updates the other endpoint changes the read-back value on the very next cycle.

// File: rtl/usb_ep_mode_bank.sv
module usb_ep_mode_bank #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h45,
  parameter logic [3:0] MODE_ACK_OUT = 4'h9,
  parameter logic [3:0] MODE_ACK_IN  = 4'hD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fw_addr,
  input  logic [7:0]        fw_wdata,
  input  logic              fw_wr,
  input  logic              fw_rd,
  output logic [7:0]        fw_rdata,
  input  logic              sie_mode_wr,
  input  logic              sie_mode_ep,
  input  logic [3:0]        sie_mode_val,
  input  logic              txn_done,
  input  logic              txn_ep,
  input  logic              txn_acked,
  input  logic              qry_ep,
  input  logic              qry_is_in,
  output logic              stall_resp,
  output logic [1:0]        ep_irq
);
  localparam int NEP = 2;
  localparam logic [ADDR_W-1:0] ADDR_B = ADDR_W'(BASE_ADDR + 1);

  logic [NEP-1:0] stall, nak_en, acked, fw_sel, fw_take, ack_hit, irq_d;
  logic [3:0]     mode [NEP];

  assign fw_sel  = {fw_addr == ADDR_B, fw_addr == BASE_ADDR};
  assign fw_take = (fw_wr && !sie_mode_wr) ? fw_sel : '0;

  genvar g;
  generate
    for (g = 0; g < NEP; g++) begin : g_ep
      assign ack_hit[g] = txn_done && txn_acked && (txn_ep == 1'(g));
      assign irq_d[g]   = txn_done && (txn_ep == 1'(g)) && (txn_acked || nak_en[g]);

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stall[g]  <= 1'b0;
          nak_en[g] <= 1'b0;
          acked[g]  <= 1'b0;
          mode[g]   <= 4'h0;
          ep_irq[g] <= 1'b0;
        end else begin
          if (fw_take[g]) begin
            stall[g]  <= fw_wdata[7];
            nak_en[g] <= fw_wdata[5];
            mode[g]   <= fw_wdata[3:0];
          end
          if (sie_mode_wr && sie_mode_ep == 1'(g))
            mode[g] <= sie_mode_val;
          if (ack_hit[g])
            acked[g] <= 1'b1;
          else if (fw_take[g])
            acked[g] <= 1'b0;
          ep_irq[g] <= irq_d[g];
        end
      end

      // R5
      ack_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_hit[g] |=> acked[g]);
      // R6
      ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_take[g] && !ack_hit[g]) |=> !acked[g]);
      // R7
      ack_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_hit[g] |=> ep_irq[g]);
      // R8
      nak_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_done && !txn_acked && txn_ep == 1'(g) && !nak_en[g]) |=> !ep_irq[g]);
      // R10
      lost_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sie_mode_wr && sie_mode_ep != 1'(g)) |=>
          ($stable(mode[g]) && $stable(stall[g]) && $stable(nak_en[g])));
    end
  endgenerate

  function automatic logic [7:0] pack(input int e);
    return {stall[e], 1'b0, nak_en[e], acked[e], mode[e]};
  endfunction

  always_comb begin
    fw_rdata = 8'h00;
    if (fw_rd) begin
      if (fw_sel[0])      fw_rdata = pack(0);
      else if (fw_sel[1]) fw_rdata = pack(1);
    end
  end

  assign stall_resp = stall[qry_ep] &&
    (qry_is_in ? (mode[qry_ep] == MODE_ACK_IN) : (mode[qry_ep] == MODE_ACK_OUT));

  // R9
  stall_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_resp |-> (mode[qry_ep] == MODE_ACK_IN || mode[qry_ep] == MODE_ACK_OUT));
  // R7
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ep_irq));
endmodule

// File: tb/usb_ep_mode_bank_tb.sv
module usb_ep_mode_bank_tb;
  localparam logic [7:0] A0 = 8'h45, A1 = 8'h46;
  localparam logic [3:0] M_OUT = 4'h9, M_IN = 4'hD;

  logic clk = 0, rst_n = 0;
  logic [7:0] fw_addr = 0, fw_wdata = 0, fw_rdata;
  logic fw_wr = 0, fw_rd = 0;
  logic sie_mode_wr = 0, sie_mode_ep = 0;
  logic [3:0] sie_mode_val = 0;
  logic txn_done = 0, txn_ep = 0, txn_acked = 0;
  logic qry_ep = 0, qry_is_in = 0, stall_resp;
  logic [1:0] ep_irq;

  int ntests = 0, nfail = 0;

  logic m_stall [2], m_nak [2], m_ack [2], m_irq [2];
  logic [3:0] m_mode [2];

  always #5 clk = ~clk;

  usb_ep_mode_bank u_dut (
    .clk, .rst_n, .fw_addr, .fw_wdata, .fw_wr, .fw_rd, .fw_rdata,
    .sie_mode_wr, .sie_mode_ep, .sie_mode_val, .txn_done, .txn_ep, .txn_acked,
    .qry_ep, .qry_is_in, .stall_resp, .ep_irq);

  function automatic logic [7:0] exp_reg(input int e);
    return {m_stall[e], 1'b0, m_nak[e], m_ack[e], m_mode[e]};
  endfunction

  function automatic logic [7:0] exp_rd();
    if (!fw_rd) return 8'h00;
    if (fw_addr == A0) return exp_reg(0);
    if (fw_addr == A1) return exp_reg(1);
    return 8'h00;
  endfunction

  function automatic logic exp_stall();
    return m_stall[qry_ep] && (qry_is_in ? m_mode[qry_ep] == M_IN : m_mode[qry_ep] == M_OUT);
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic idle();
    fw_wr = 0; fw_rd = 0; sie_mode_wr = 0; txn_done = 0;
  endtask

  task automatic cyc();
    logic n_stall [2], n_nak [2], n_ack [2], n_irq [2];
    logic [3:0] n_mode [2];
    #1;
    check("R2 read data", fw_rdata, exp_rd());
    check("R9 stall response", {7'b0, stall_resp}, {7'b0, exp_stall()});
    check("R7 irq", {6'b0, ep_irq}, {6'b0, m_irq[1], m_irq[0]});
    for (int e = 0; e < 2; e++) begin
      logic take, ackh;
      take = fw_wr && !sie_mode_wr && (fw_addr == (e == 0 ? A0 : A1));
      ackh = txn_done && txn_acked && (txn_ep == 1'(e));
      n_stall[e] = take ? fw_wdata[7] : m_stall[e];
      n_nak[e]   = take ? fw_wdata[5] : m_nak[e];
      n_mode[e]  = (sie_mode_wr && sie_mode_ep == 1'(e)) ? sie_mode_val :
                   take ? fw_wdata[3:0] : m_mode[e];
      n_ack[e]   = ackh ? 1'b1 : take ? 1'b0 : m_ack[e];
      n_irq[e]   = txn_done && (txn_ep == 1'(e)) && (txn_acked || m_nak[e]);
    end
    @(posedge clk);
    for (int e = 0; e < 2; e++) begin
      m_stall[e] = n_stall[e]; m_nak[e] = n_nak[e]; m_mode[e] = n_mode[e];
      m_ack[e] = n_ack[e]; m_irq[e] = n_irq[e];
    end
    @(negedge clk);
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
    fw_rd = 1; fw_addr = a; #1;
    check(tag, fw_rdata, exp);
    fw_rd = 0;
  endtask

  task automatic fw_write(input logic [7:0] a, input logic [7:0] d);
    idle(); fw_wr = 1; fw_addr = a; fw_wdata = d; cyc(); idle();
  endtask

  task automatic txn(input logic ep, input logic ack);
    idle(); txn_done = 1; txn_ep = ep; txn_acked = ack; cyc(); idle();
  endtask

  initial begin
    #1ms;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int e = 0; e < 2; e++) begin
      m_stall[e] = 0; m_nak[e] = 0; m_ack[e] = 0; m_irq[e] = 0; m_mode[e] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1
    check("R1 irq after reset", {6'b0, ep_irq}, 8'h00);
    check("R1 stall after reset", {7'b0, stall_resp}, 8'h00);
    rd_chk(A0, 8'h00, "R1 reg A reset");
    rd_chk(A1, 8'h00, "R1 reg B reset");
    rd_chk(8'h47, 8'h00, "R2 unmapped read");

    // R3, R4: all ones written, bit 6 and ACK bit stay clear
    fw_write(A0, 8'hFF);
    rd_chk(A0, 8'hAF, "R3 reserved bit reads 0");
    fw_write(A1, 8'h23);
    rd_chk(A1, 8'h23, "R4 fields loaded");
    rd_chk(A1, 8'h23, "R11 repeated read stable");

    // R5, R7
    fw_write(A0, 8'h09);
    txn(0, 1);
    check("R7 ack irq pulse", {6'b0, ep_irq}, 8'h01);
    rd_chk(A0, 8'h19, "R5 ack bit set");
    cyc();
    check("R7 irq one cycle", {6'b0, ep_irq}, 8'h00);
    // R6
    fw_write(A0, 8'h19);
    rd_chk(A0, 8'h09, "R6 write clears ack");
    idle(); fw_wr = 1; fw_addr = A0; fw_wdata = 8'h09;
    txn_done = 1; txn_ep = 0; txn_acked = 1; cyc(); idle();
    rd_chk(A0, 8'h19, "R6 set wins over clear");

    // R8
    fw_write(A0, 8'h09);
    txn(0, 0);
    check("R8 nak no irq when disabled", {6'b0, ep_irq}, 8'h00);
    txn(1, 0);
    check("R8 nak irq when enabled", {6'b0, ep_irq}, 8'h02);

    // R9
    fw_write(A0, 8'h89);
    fw_write(A1, 8'h8D);
    qry_ep = 0; qry_is_in = 0; #1;
    check("R9 stall OUT in ACK-OUT", {7'b0, stall_resp}, 8'h01);
    qry_is_in = 1; #1;
    check("R9 no stall IN in ACK-OUT", {7'b0, stall_resp}, 8'h00);
    qry_ep = 1; #1;
    check("R9 stall IN in ACK-IN", {7'b0, stall_resp}, 8'h01);
    qry_is_in = 0; #1;
    check("R9 no stall OUT in ACK-IN", {7'b0, stall_resp}, 8'h00);

    // R10: SIE update on A, firmware write to B lost
    fw_write(A1, 8'hA3);
    idle(); sie_mode_wr = 1; sie_mode_ep = 0; sie_mode_val = 4'h5;
    fw_wr = 1; fw_addr = A1; fw_wdata = 8'h20; cyc(); idle();
    rd_chk(A1, 8'hA3, "R10 firmware write lost");
    rd_chk(A0, 8'h85, "R10 SIE mode applied");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] s;
      s = 3'($urandom);
      fw_addr = (s < 3) ? A0 : (s < 6) ? A1 : 8'($urandom);
      fw_wdata = 8'($urandom);
      fw_wr = ($urandom % 10) < 4;
      fw_rd = ($urandom % 10) < 7;
      sie_mode_wr = ($urandom % 10) < 2;
      sie_mode_ep = 1'($urandom);
      sie_mode_val = ($urandom % 3 == 0) ? M_IN : ($urandom % 2 == 0) ? M_OUT : 4'($urandom);
      txn_done = ($urandom % 10) < 4;
      txn_ep = 1'($urandom);
      txn_acked = 1'($urandom);
      qry_ep = 1'($urandom);
      qry_is_in = 1'($urandom);
      cyc();
    end
    idle();
    cyc();
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule